// File: doc/BRIEF.md
# SPI Data Buffer and Status Flags

This block sits between a byte-wide register bus and a serial shift engine. It holds a transmit word that software builds up one byte at a time. It also holds a receive word that software reads back one byte at a time. Three flags track the state of the two buffers: receive-ready, transmit-empty and overrun. A one-cycle transmit interrupt is raised each time the engine takes a word. The serial shifting is done elsewhere. The engine only asks for the next transmit word (load) and hands back a received word (done).

Only the low data byte moves the flags. A read of it clears receive-ready and overrun. A write to it clears transmit-empty. The high byte never touches the flags. What happens on a receive overrun depends on the mode. In master mode the new word replaces the old one. In slave mode the old word is kept. In both modes the overrun flag is set. When the engine sets a flag in the same cycle that a bus access clears it, the set wins.

Top module: `spi_word_buffers`

## Requirements
- R1: While `rst_n` is low, or `blk_en` is low at a clock edge, both buffers become zero, receive-ready and overrun become 0, transmit-empty becomes 1 and `tx_irq` becomes 0. In that state the status byte reads 0x02.
- R2: A cycle with `eng_done` high stores `eng_rxword` (when R5 allows it) and sets receive-ready at the next edge. The stored word reads back at address 0 (bits 7:0) and address 1 (bits 15:8).
- R3: A read strobe at address 0 clears receive-ready and overrun. A read strobe at address 1 changes no flag.
- R4: With `master_mode`=1, a done while receive-ready is 1 overwrites the receive buffer and sets overrun.
- R5: With `master_mode`=0, a done while receive-ready is 1 leaves the receive buffer unchanged and sets overrun.
- R6: Any write to address 2 (the status byte) clears overrun, whatever data is written, and leaves receive-ready alone.
- R7: A write to address 0 stores `bus_wdata` in transmit bits 7:0 and clears transmit-empty. A write to address 1 stores bits 15:8 and leaves transmit-empty unchanged.
- R8: `eng_txword` always shows the transmit buffer. A cycle with `eng_load` high sets transmit-empty at the next edge and drives `tx_irq` high for exactly the following cycle.
- R9: A load while transmit-empty is 1 hands the engine the previous buffer contents.
- R10: A flag set wins over a same-cycle clear. A done together with an address-0 read leaves receive-ready at 1. A load together with an address-0 write leaves transmit-empty at 1, and the engine gets the word as it was before the write.
- R11: The status byte at address 2 holds receive-ready in bit 0, transmit-empty in bit 1 and overrun in bit 2, with all other bits 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Block enable; low clears all state |
| master_mode | input | 1 | 1 = master (overwrite on overrun), 0 = slave (keep old word) |
| bus_addr | input | 2 | Register address: 0 data low, 1 data high, 2 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| eng_load | input | 1 | Engine takes the transmit word this cycle |
| eng_txword | output | 16 | Transmit buffer contents |
| eng_done | input | 1 | Engine finished an exchange this cycle |
| eng_rxword | input | 16 | Word received by the engine |
| tx_irq | output | 1 | One-cycle transmit interrupt after each load |

## Verification
The bench targets several cases that a wrong design would get visibly wrong:
- A second word arriving in slave mode. If the design overwrote it anyway, the read-back word would change.
- A read of the high byte. If the design decoded the address too loosely, that read would drop receive-ready.
- A done and a low-byte read in the same cycle. If the clear had priority, receive-ready would be lost.
- A low-byte write in the same cycle as a load. If the clear had priority, transmit-empty would stay 0. If the buffer were not read before the write, the engine would receive the new byte.
- Dropping the enable. A design that did not clear everything would leave stale flags or stale data visible on the bus.

// File: rtl/swb_pkg.sv
package swb_pkg;
   localparam int ST_RX_READY = 0;
   localparam int ST_TX_EMPTY = 1;
   localparam int ST_OVERRUN  = 2;
   localparam int ST_USED     = 3;

   typedef struct packed {
      logic overrun;
      logic tx_empty;
      logic rx_ready;
   } swb_flags_t;
endpackage

// File: rtl/swb_tx_hold.sv
module swb_tx_hold #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   localparam int NLANE = DATA_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [NLANE-1:0]  lane_we,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              load,
   output logic [DATA_W-1:0] txword,
   output logic              tx_empty,
   output logic              tx_irq
);
   logic [DATA_W-1:0] hold_q;

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          hold_q[i*BYTE_W +: BYTE_W] <= '0;
         else if (!en)        hold_q[i*BYTE_W +: BYTE_W] <= '0;
         else if (lane_we[i]) hold_q[i*BYTE_W +: BYTE_W] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_empty <= 1'b1;
         tx_irq   <= 1'b0;
      end else if (!en) begin
         tx_empty <= 1'b1;
         tx_irq   <= 1'b0;
      end else begin
         tx_irq <= load;
         if (load)            tx_empty <= 1'b1;
         else if (lane_we[0]) tx_empty <= 1'b0;
      end
   end

   assign txword = hold_q;

   AST_TX_DISABLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !en |=> tx_empty && !tx_irq); // R1
   AST_TX_LOW_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) en && lane_we[0] && !load |=> !tx_empty); // R7
   AST_TX_HIGH_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) en && lane_we[NLANE-1] && !lane_we[0] && !load |=> $stable(tx_empty)); // R7
   AST_TX_LOAD_IRQ: assert property (@(posedge clk) disable iff (!rst_n) en && load |=> tx_empty && tx_irq); // R8
   AST_TX_IRQ_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n) en && !load |=> !tx_irq); // R8
   AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) en && load && lane_we[0] |=> tx_empty); // R10
endmodule

// File: rtl/swb_rx_hold.sv
module swb_rx_hold #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              master,
   input  logic              done,
   input  logic [DATA_W-1:0] rxword,
   input  logic              rd_low,
   input  logic              stat_wr,
   output logic [DATA_W-1:0] rxbuf,
   output logic              rx_ready,
   output logic              overrun
);
   logic take, ovr_evt;

   assign ovr_evt = done && rx_ready;
   assign take    = done && (master || !rx_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxbuf    <= '0;
         rx_ready <= 1'b0;
         overrun  <= 1'b0;
      end else if (!en) begin
         rxbuf    <= '0;
         rx_ready <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         if (take) rxbuf <= rxword;
         if (done)        rx_ready <= 1'b1;
         else if (rd_low) rx_ready <= 1'b0;
         if (ovr_evt)                overrun <= 1'b1;
         else if (rd_low || stat_wr) overrun <= 1'b0;
      end
   end

   AST_RX_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !rx_ready && !overrun && rxbuf == '0); // R1
   AST_RX_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n) en && done |=> rx_ready); // R2
   AST_RX_HIGH_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) en && !done && !rd_low && !stat_wr |=> $stable(rx_ready) && $stable(overrun)); // R3
   AST_RX_MASTER_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n) en && done && master |=> rxbuf == $past(rxword)); // R4
   AST_RX_SLAVE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) en && done && !master && rx_ready |=> $stable(rxbuf) && overrun); // R5
   AST_RX_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) en && stat_wr && !done && !rd_low |=> !overrun && $stable(rx_ready)); // R6
endmodule

// File: rtl/swb_read_mux.sv
module swb_read_mux
   import swb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2,
   localparam int NLANE = DATA_W / BYTE_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] rxbuf,
   input  swb_flags_t        flags,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] status;

   always_comb begin
      status              = '0;
      status[ST_RX_READY] = flags.rx_ready;
      status[ST_TX_EMPTY] = flags.tx_empty;
      status[ST_OVERRUN]  = flags.overrun;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NLANE; i++)
         if (addr == ADDR_W'(i)) rdata = rxbuf[i*BYTE_W +: BYTE_W];
      if (addr == ADDR_W'(NLANE)) rdata = status;
   end
endmodule

// File: rtl/spi_word_buffers.sv
module spi_word_buffers
   import swb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_en,
   input  logic              master_mode,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              eng_load,
   output logic [DATA_W-1:0] eng_txword,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_rxword,
   output logic              tx_irq
);
   localparam int NLANE     = DATA_W / BYTE_W;
   localparam int STAT_ADDR = NLANE;

   if (DATA_W % BYTE_W != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (NLANE < 2) begin : g_bad_lanes
      $error("need at least two byte lanes");
   end
   if (BYTE_W < ST_USED) begin : g_bad_byte
      $error("byte too narrow for status bits");
   end
   if ((1 << ADDR_W) <= STAT_ADDR) begin : g_bad_addr
      $error("ADDR_W too small to reach status byte");
   end

   logic [NLANE-1:0] lane_we;
   logic             rd_low, stat_wr;
   logic [DATA_W-1:0] rxbuf;
   swb_flags_t       flags;

   for (genvar i = 0; i < NLANE; i++) begin : g_dec
      assign lane_we[i] = bus_wr && (bus_addr == ADDR_W'(i));
   end
   assign rd_low  = bus_rd && (bus_addr == '0);
   assign stat_wr = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));

   swb_tx_hold #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(blk_en), .lane_we(lane_we),
      .wdata(bus_wdata), .load(eng_load), .txword(eng_txword),
      .tx_empty(flags.tx_empty), .tx_irq(tx_irq)
   );

   swb_rx_hold #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(blk_en), .master(master_mode),
      .done(eng_done), .rxword(eng_rxword), .rd_low(rd_low),
      .stat_wr(stat_wr), .rxbuf(rxbuf), .rx_ready(flags.rx_ready),
      .overrun(flags.overrun)
   );

   swb_read_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_mux (
      .addr(bus_addr), .rxbuf(rxbuf), .flags(flags), .rdata(bus_rdata)
   );

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({lane_we, stat_wr})); // R11
   AST_READ_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) blk_en && eng_done && rd_low |=> flags.rx_ready); // R10
endmodule

// File: tb/spi_word_buffers_bench.sv
module spi_word_buffers_bench;
   typedef struct packed {
      logic        wr;
      logic        rd;
      logic [1:0]  addr;
      logic [7:0]  wdata;
      logic        done;
      logic [15:0] rxw;
      logic        load;
      logic        master;
      logic [7:0]  est;
      logic [15:0] erx;
      logic [15:0] etx;
      logic        eirq;
      logic [7:0]  req;
   } vec_t;

   // fields: wr rd addr wdata done rxw load master | status rxword txword irq req
   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,2'd0,8'h34,1'b0,16'h0000,1'b0,1'b1, 8'h00,16'h0000,16'h0000,1'b0,8'd7},  // R7 low write
      '{1'b1,1'b0,2'd1,8'h12,1'b0,16'h0000,1'b0,1'b1, 8'h00,16'h0000,16'h0000,1'b0,8'd7},  // R7 high write
      '{1'b0,1'b0,2'd0,8'h00,1'b0,16'h0000,1'b1,1'b1, 8'h02,16'h0000,16'h1234,1'b1,8'd8},  // R8 load
      '{1'b0,1'b0,2'd0,8'h00,1'b0,16'h0000,1'b0,1'b1, 8'h02,16'h0000,16'h0000,1'b0,8'd8},  // R8 irq drops
      '{1'b0,1'b0,2'd0,8'h00,1'b1,16'hA1B2,1'b0,1'b1, 8'h03,16'hA1B2,16'h0000,1'b0,8'd2},  // R2 receive
      '{1'b0,1'b1,2'd1,8'h00,1'b0,16'h0000,1'b0,1'b1, 8'h03,16'hA1B2,16'h0000,1'b0,8'd3},  // R3 high read
      '{1'b0,1'b0,2'd0,8'h00,1'b1,16'hC3D4,1'b0,1'b1, 8'h07,16'hC3D4,16'h0000,1'b0,8'd4},  // R4 master overrun
      '{1'b0,1'b1,2'd0,8'h00,1'b0,16'h0000,1'b0,1'b1, 8'h02,16'hC3D4,16'h0000,1'b0,8'd3},  // R3 low read
      '{1'b0,1'b0,2'd0,8'h00,1'b1,16'h5566,1'b0,1'b0, 8'h03,16'h5566,16'h0000,1'b0,8'd2},  // R2 slave receive
      '{1'b0,1'b0,2'd0,8'h00,1'b1,16'h7788,1'b0,1'b0, 8'h07,16'h5566,16'h0000,1'b0,8'd5},  // R5 slave keeps
      '{1'b1,1'b0,2'd2,8'hFF,1'b0,16'h0000,1'b0,1'b0, 8'h03,16'h5566,16'h0000,1'b0,8'd6},  // R6 status write
      '{1'b0,1'b0,2'd0,8'h00,1'b1,16'h99AA,1'b0,1'b0, 8'h07,16'h5566,16'h0000,1'b0,8'd5},  // R5 again
      '{1'b0,1'b1,2'd0,8'h00,1'b1,16'hBBCC,1'b0,1'b0, 8'h07,16'h5566,16'h0000,1'b0,8'd10}, // R10 read+done
      '{1'b0,1'b1,2'd0,8'h00,1'b0,16'h0000,1'b0,1'b1, 8'h02,16'h5566,16'h0000,1'b0,8'd3},  // R3 clear both
      '{1'b0,1'b0,2'd0,8'h00,1'b0,16'h0000,1'b1,1'b1, 8'h02,16'h5566,16'h1234,1'b1,8'd9},  // R9 load while empty
      '{1'b1,1'b0,2'd0,8'h56,1'b0,16'h0000,1'b1,1'b1, 8'h02,16'h5566,16'h1234,1'b1,8'd10}, // R10 write+load
      '{1'b0,1'b0,2'd0,8'h00,1'b0,16'h0000,1'b1,1'b1, 8'h02,16'h5566,16'h1256,1'b1,8'd8},  // R8 new word
      '{1'b0,1'b0,2'd0,8'h00,1'b0,16'h0000,1'b0,1'b1, 8'h02,16'h5566,16'h0000,1'b0,8'd8}   // R8 irq drops
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_en = 1'b1;
   logic        master_mode = 1'b1;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        eng_load = 1'b0;
   logic [15:0] eng_txword;
   logic        eng_done = 1'b0;
   logic [15:0] eng_rxword = '0;
   logic        tx_irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spi_word_buffers u_spi_word_buffers (
      .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .master_mode(master_mode),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_load(eng_load),
      .eng_txword(eng_txword), .eng_done(eng_done), .eng_rxword(eng_rxword),
      .tx_irq(tx_irq)
   );

   task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic peek(string tag, logic [7:0] est, logic [15:0] erx, logic eirq);
      bus_addr = 2'd2; #1;
      check_eq({tag, " status"}, 32'(bus_rdata), 32'(est));
      bus_addr = 2'd0; #1;
      check_eq({tag, " rx low"}, 32'(bus_rdata), 32'(erx[7:0]));
      bus_addr = 2'd1; #1;
      check_eq({tag, " rx high"}, 32'(bus_rdata), 32'(erx[15:8]));
      check_eq({tag, " irq"}, 32'(tx_irq), 32'(eirq));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      peek("R1 reset", 8'h02, 16'h0000, 1'b0);
      check_eq("R1 reset txword", 32'(eng_txword), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
         bus_wr      = VECS[v].wr;
         bus_rd      = VECS[v].rd;
         bus_addr    = VECS[v].addr;
         bus_wdata   = VECS[v].wdata;
         eng_done    = VECS[v].done;
         eng_rxword  = VECS[v].rxw;
         eng_load    = VECS[v].load;
         master_mode = VECS[v].master;
         #1;
         if (VECS[v].load) check_eq({tag, " txword"}, 32'(eng_txword), 32'(VECS[v].etx));
         @(posedge clk);
         @(negedge clk);
         bus_wr = 1'b0; bus_rd = 1'b0; eng_done = 1'b0; eng_load = 1'b0;
         peek(tag, VECS[v].est, VECS[v].erx, VECS[v].eirq);
      end

      // R11: unused address reads zero
      bus_addr = 2'd3; #1;
      check_eq("R11 addr3", 32'(bus_rdata), 32'h0);

      // R1: drop enable with data and flags present
      @(negedge clk);
      eng_done = 1'b1; eng_rxword = 16'h0F0F; master_mode = 1'b1;
      @(negedge clk);
      eng_done = 1'b0; eng_load = 1'b1;
      @(negedge clk);
      eng_load = 1'b0; blk_en = 1'b0;
      @(negedge clk);
      peek("R1 disable", 8'h02, 16'h0000, 1'b0);
      check_eq("R1 disable txword", 32'(eng_txword), 32'h0);
      blk_en = 1'b1;

      // R6: status write with zero data still clears overrun
      eng_done = 1'b1; eng_rxword = 16'h1111;
      @(negedge clk);
      eng_rxword = 16'h2222;
      @(negedge clk);
      eng_done = 1'b0; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h00;
      @(negedge clk);
      bus_wr = 1'b0;
      peek("R6 zero write", 8'h03, 16'h2222, 1'b0);

      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule